// File: doc/BRIEF.md
# Multi-Digit Radix Adder with Single-Pass Carry Resolution

This block adds two numbers held as vectors of digits, where every digit is a small unsigned field and the number base is an input value instead of a fixed power of two. Each digit lane first adds its two input digits with no carry. From that raw sum it decides whether the lane creates a carry on its own (the raw sum is larger than the highest digit value) or only passes an incoming carry along (the raw sum equals the highest digit value).

These per-lane flags are packed side by side into two lane-wide integers. One ordinary binary addition over those integers then gives the carry into every lane at once, including long ripple chains. Each lane adds its carry to its raw sum and wraps the result back below the radix.

The block reports the resulting digits, the carry out of the top lane, and a flag that shows whether any carry moved at all. The result goes through one register stage and comes out with a valid strobe. Typical uses are big-number arithmetic in decimal or other non-binary bases, and building per-lane carry masks.

Top module: `radix_carry_adder`

## Requirements
- R1: Each output digit i equals (A[i] + B[i] + c[i]) mod radix, where c[i] is the carry into lane i and digit i occupies bits [i*DIGIT_W +: DIGIT_W] of every digit vector.
- R2: The carry into lane 0 is the external carry-in bit.
- R3: For i > 0, lane i receives a carry when the raw sum of lane i-1 is greater than radix-1, or when it equals radix-1 and lane i-1 itself receives a carry; chains of any length, up to all lanes, are resolved in the same pass.
- R4: The carry-out is 1 when lane N-1 creates a carry or passes on one it receives, under the same rule as R3.
- R5: The activity flag is 1 when any lane receives a carry or the carry-out is 1, and is 0 when no carry moves anywhere.
- R6: Any radix from 2 to 2^DIGIT_W is accepted; with radix 2^DIGIT_W the digit vector result equals the plain binary sum of the packed operands plus carry-in, modulo 2^(N*DIGIT_W), with the carry-out as bit N*DIGIT_W.
- R7: Results appear one clock after a cycle with in_valid high, together with out_valid high; in a cycle with in_valid low, out_valid drops and the result outputs keep their previous values.
- R8: While rst_n is low, out_valid, the result digits, the carry-out and the activity flag are all 0.
- R9: Every output digit is below the radix when both input digits are below the radix.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Inputs present this cycle |
| carry_in | input | 1 | Carry into lane 0 |
| radix | input | DIGIT_W+1 | Number base, 2 to 2^DIGIT_W |
| a_digits | input | N_LANES*DIGIT_W | First operand digits, lane 0 in low bits |
| b_digits | input | N_LANES*DIGIT_W | Second operand digits, lane 0 in low bits |
| out_valid | output | 1 | Registered result valid |
| sum_digits | output | N_LANES*DIGIT_W | Result digits, lane 0 in low bits |
| carry_out | output | 1 | Carry out of the top lane |
| carry_seen | output | 1 | Any carry moved in this operation |

## Verification
The adder is driven with operands of all top digits plus a carry-in, which separates a one-pass carry resolver from one that only looks a single lane ahead. All-zero operands with carry-in set and then clear check that the carry-in lands only in lane 0, and that the activity flag falls when no carry moves. Radix 2^DIGIT_W is compared against plain integer addition, which separates the modular reduction from a binary add. Random radices from 2 to 16 with random legal digits exercise mixed generate, propagate and kill patterns, and idle cycles with changed inputs show that the result is held.

// File: rtl/rca_pkg.sv
package rca_pkg;
    localparam int unsigned RCA_MAX_LANES = 64;
    localparam int unsigned RCA_MIN_RADIX = 2;

    typedef enum logic [1:0] {
        LANE_KILL = 2'b00,
        LANE_PROP = 2'b01,
        LANE_GEN  = 2'b10
    } lane_kind_e;
endpackage

// File: rtl/rca_lane_classify.sv
module rca_lane_classify #(
    parameter int unsigned DIGIT_W = 4
) (
    input  logic [DIGIT_W-1:0] a_dig,
    input  logic [DIGIT_W-1:0] b_dig,
    input  logic [DIGIT_W:0]   radix,
    output logic [DIGIT_W:0]   raw_sum,
    output logic               gen,
    output logic               prop
);
    import rca_pkg::*;

    logic [DIGIT_W:0] top_digit;
    lane_kind_e       kind;

    always_comb begin
        raw_sum   = {1'b0, a_dig} + {1'b0, b_dig};
        top_digit = radix - 1'b1;
        if (raw_sum > top_digit) begin
            kind = LANE_GEN;
        end else if (raw_sum == top_digit) begin
            kind = LANE_PROP;
        end else begin
            kind = LANE_KILL;
        end
        gen  = (kind == LANE_GEN);
        prop = (kind == LANE_PROP);
    end

    // R3: a lane never both creates and only forwards a carry
    always_comb begin
        assert_gen_prop_exclusive_R3: assert (!(gen && prop))
            else $error("lane flagged as generate and propagate");
    end
endmodule

// File: rtl/rca_carry_resolve.sv
module rca_carry_resolve #(
    parameter int unsigned N_LANES = 8
) (
    input  logic [N_LANES-1:0] gen_vec,
    input  logic [N_LANES-1:0] prop_vec,
    input  logic               cin,
    output logic [N_LANES-1:0] lane_cin,
    output logic               cout,
    output logic               moved
);
    localparam int unsigned WIDE = N_LANES + 1;

    logic [WIDE-1:0] pg_wide;
    logic [WIDE-1:0] g_wide;
    logic [WIDE-1:0] c_wide;
    logic [WIDE-1:0] acc;

    always_comb begin
        pg_wide  = {1'b0, prop_vec | gen_vec};
        g_wide   = {1'b0, gen_vec};
        c_wide   = {{N_LANES{1'b0}}, cin};
        acc      = pg_wide + g_wide + c_wide;
        lane_cin = acc[N_LANES-1:0] ^ prop_vec;
        cout     = acc[N_LANES];
        moved    = (|lane_cin) | cout;
    end

    // R2: the carry-in lands in lane 0
    always_comb begin
        assert_lane0_carry_R2: assert (lane_cin[0] == cin)
            else $error("lane 0 carry differs from carry-in");
        assert_top_carry_R4: assert (cout == (gen_vec[N_LANES-1] |
                                     (prop_vec[N_LANES-1] & lane_cin[N_LANES-1])))
            else $error("carry-out disagrees with ripple rule");
    end

    // R3: each lane carry matches a ripple step from its neighbour
    for (genvar i = 1; i < N_LANES; i++) begin : g_ripple_chk
        always_comb begin
            assert_ripple_step_R3: assert (lane_cin[i] ==
                                   (gen_vec[i-1] | (prop_vec[i-1] & lane_cin[i-1])))
                else $error("lane carry disagrees with ripple rule");
        end
    end
endmodule

// File: rtl/rca_digit_fix.sv
module rca_digit_fix #(
    parameter int unsigned DIGIT_W = 4
) (
    input  logic [DIGIT_W:0]   raw_sum,
    input  logic               lane_carry,
    input  logic [DIGIT_W:0]   radix,
    input  logic               ops_legal,
    output logic [DIGIT_W-1:0] digit
);
    logic [DIGIT_W:0] with_carry;
    logic [DIGIT_W:0] wrapped;

    always_comb begin
        with_carry = raw_sum + {{DIGIT_W{1'b0}}, lane_carry};
        if (with_carry >= radix) begin
            wrapped = with_carry - radix;
        end else begin
            wrapped = with_carry;
        end
        digit = wrapped[DIGIT_W-1:0];
    end

    // R9: the wrapped digit fits below the radix
    always_comb begin
        if (ops_legal) begin
            assert_digit_below_radix_R9: assert (wrapped < radix)
                else $error("digit not below radix");
        end
    end
endmodule

// File: rtl/radix_carry_adder.sv
module radix_carry_adder #(
    parameter int unsigned N_LANES = 8,
    parameter int unsigned DIGIT_W = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic                         carry_in,
    input  logic [DIGIT_W:0]             radix,
    input  logic [N_LANES*DIGIT_W-1:0]   a_digits,
    input  logic [N_LANES*DIGIT_W-1:0]   b_digits,
    output logic                         out_valid,
    output logic [N_LANES*DIGIT_W-1:0]   sum_digits,
    output logic                         carry_out,
    output logic                         carry_seen
);
    import rca_pkg::*;

    localparam int unsigned VEC_W = N_LANES * DIGIT_W;

    typedef struct packed {
        logic             vld;
        logic [VEC_W-1:0] digits;
        logic             cout;
        logic             seen;
    } out_state_t;

    out_state_t st_d, st_q;

    logic [N_LANES-1:0] gen_vec;
    logic [N_LANES-1:0] prop_vec;
    logic [N_LANES-1:0] lane_cin;
    logic [N_LANES-1:0] lane_ok;
    logic [DIGIT_W:0]   raw_sum [N_LANES];
    logic [VEC_W-1:0]   fixed_digits;
    logic               cout_c;
    logic               moved_c;
    logic               radix_ok;

    initial begin
        assert_lane_count_range: assert (N_LANES >= 1 && N_LANES <= RCA_MAX_LANES)
            else $error("lane count out of range");
    end

    always_comb begin
        radix_ok = (radix >= (DIGIT_W+1)'(RCA_MIN_RADIX)) &&
                   (radix <= (DIGIT_W+1)'(1) << DIGIT_W);
    end

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        rca_lane_classify #(.DIGIT_W(DIGIT_W)) u_classify (
            .a_dig   (a_digits[i*DIGIT_W +: DIGIT_W]),
            .b_dig   (b_digits[i*DIGIT_W +: DIGIT_W]),
            .radix   (radix),
            .raw_sum (raw_sum[i]),
            .gen     (gen_vec[i]),
            .prop    (prop_vec[i])
        );

        always_comb begin
            lane_ok[i] = radix_ok &&
                         ({1'b0, a_digits[i*DIGIT_W +: DIGIT_W]} < radix) &&
                         ({1'b0, b_digits[i*DIGIT_W +: DIGIT_W]} < radix);
        end

        rca_digit_fix #(.DIGIT_W(DIGIT_W)) u_fix (
            .raw_sum    (raw_sum[i]),
            .lane_carry (lane_cin[i]),
            .radix      (radix),
            .ops_legal  (lane_ok[i]),
            .digit      (fixed_digits[i*DIGIT_W +: DIGIT_W])
        );
    end

    rca_carry_resolve #(.N_LANES(N_LANES)) u_resolve (
        .gen_vec  (gen_vec),
        .prop_vec (prop_vec),
        .cin      (carry_in),
        .lane_cin (lane_cin),
        .cout     (cout_c),
        .moved    (moved_c)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.digits = fixed_digits;
            st_d.cout   = cout_c;
            st_d.seen   = moved_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.vld;
    assign sum_digits = st_q.digits;
    assign carry_out  = st_q.cout;
    assign carry_seen = st_q.seen;

    // R7: valid strobe follows the input strobe by one cycle
    assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_drops_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_idle_holds_result_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_digits) && $stable(carry_out) && $stable(carry_seen)));
    // R5: a carry-out always counts as carry activity
    assert_cout_implies_seen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        carry_out |-> carry_seen);
endmodule

// File: tb/radix_carry_adder_tb_top.sv
`timescale 1ns/1ps
module radix_carry_adder_tb_top;
    localparam int unsigned N = 8;
    localparam int unsigned W = 4;
    localparam int unsigned NW = N * W;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          carry_in = 1'b0;
    logic [W:0]    radix = 5'd10;
    logic [NW-1:0] a_digits = '0;
    logic [NW-1:0] b_digits = '0;
    logic          out_valid;
    logic [NW-1:0] sum_digits;
    logic          carry_out;
    logic          carry_seen;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    radix_carry_adder #(.N_LANES(N), .DIGIT_W(W)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .carry_in   (carry_in),
        .radix      (radix),
        .a_digits   (a_digits),
        .b_digits   (b_digits),
        .out_valid  (out_valid),
        .sum_digits (sum_digits),
        .carry_out  (carry_out),
        .carry_seen (carry_seen)
    );

    task automatic ref_model(input logic [NW-1:0] a, input logic [NW-1:0] b,
                             input logic cin, input int rdx,
                             output logic [NW-1:0] d, output logic co, output logic fl);
        int c = cin;
        fl = cin;
        d  = '0;
        for (int i = 0; i < N; i++) begin
            int s = int'(a[i*W +: W]) + int'(b[i*W +: W]) + c;
            c = (s >= rdx) ? 1 : 0;
            d[i*W +: W] = W'(s % rdx);
            if (c != 0) fl = 1'b1;
        end
        co = (c != 0);
    endtask

    task automatic check(input string tag, input logic [NW-1:0] act, input logic [NW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input string tag, input logic [NW-1:0] a, input logic [NW-1:0] b,
                          input logic cin, input int rdx);
        logic [NW-1:0] ed;
        logic eco, efl;
        ref_model(a, b, cin, rdx, ed, eco, efl);
        @(negedge clk);
        a_digits = a; b_digits = b; carry_in = cin; radix = (W+1)'(rdx); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " R1 R3 digits"}, sum_digits, ed);
        check({tag, " R4 carry_out"}, NW'(carry_out), NW'(eco));
        check({tag, " R5 carry_seen"}, NW'(carry_seen), NW'(efl));
        check({tag, " R7 out_valid"}, NW'(out_valid), NW'(1));
        if (rdx <= (1 << W)) begin
            for (int i = 0; i < N; i++)
                check({tag, " R9 digit below radix"}, NW'(int'(sum_digits[i*W +: W]) < rdx), NW'(1));
        end
    endtask

    function automatic logic [NW-1:0] fill(input int v);
        logic [NW-1:0] r = '0;
        for (int i = 0; i < N; i++) r[i*W +: W] = W'(v);
        return r;
    endfunction

    function automatic logic [NW-1:0] rnd_digits(input int rdx);
        logic [NW-1:0] r = '0;
        for (int i = 0; i < N; i++) r[i*W +: W] = W'($urandom % rdx);
        return r;
    endfunction

    initial begin
        #(8 * 150000);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [NW-1:0] held;
        logic [NW:0] bin;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check("R8 reset out_valid", NW'(out_valid), '0);
        check("R8 reset digits", sum_digits, '0);
        check("R8 reset carry_out", NW'(carry_out), '0);
        check("R8 reset carry_seen", NW'(carry_seen), '0);
        rst_n = 1'b1;

        // R3 full-length ripple through all top digits
        run_op("full ripple dec", fill(9), '0, 1'b1, 10);
        check("R3 full ripple zeros", sum_digits, '0);
        check("R4 full ripple carry", NW'(carry_out), NW'(1));
        // R2 carry-in enters lane 0 only
        run_op("cin only", '0, '0, 1'b1, 10);
        check("R2 lane0 gets carry-in", sum_digits, NW'(1));
        // R5 nothing moves
        run_op("quiet", '0, '0, 1'b0, 10);
        check("R5 no carry flag low", NW'(carry_seen), '0);
        run_op("all generate", fill(9), fill(9), 1'b0, 10);
        run_op("radix two ripple", fill(1), '0, 1'b1, 2);
        run_op("radix max ripple", fill(15), '0, 1'b1, 16);

        // R6 binary radix equals integer add
        for (int k = 0; k < 40; k++) begin
            logic [NW-1:0] a = rnd_digits(16);
            logic [NW-1:0] b = rnd_digits(16);
            logic c = 1'($urandom);
            run_op("R6 binary", a, b, c, 16);
            bin = {1'b0, a} + {1'b0, b} + {{NW{1'b0}}, c};
            check("R6 binary sum", sum_digits, bin[NW-1:0]);
            check("R6 binary carry", NW'(carry_out), NW'(bin[NW]));
        end

        // R7 idle cycle holds outputs while inputs change
        held = sum_digits;
        @(negedge clk);
        a_digits = fill(3); b_digits = fill(4); carry_in = 1'b1; in_valid = 1'b0;
        @(negedge clk);
        check("R7 idle holds digits", sum_digits, held);
        check("R7 idle valid low", NW'(out_valid), '0);

        // random radices and digits
        for (int k = 0; k < 300; k++) begin
            int rdx = 2 + int'($urandom % 15);
            run_op("random", rnd_digits(rdx), rnd_digits(rdx), 1'($urandom), rdx);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule